// File: doc/BRIEF.md
# Extended I/O Interrupt Router

The router accepts a wide vector of level-sensitive device interrupt lines and steers each one to one of up to four CPUs and to one of four interrupt pins on that CPU. Routing comes from two byte maps. The core map holds one byte per interrupt, and each byte names a CPU either one-hot or as a binary id. The pin map holds one byte per group of 32 interrupts and always names a pin one-hot. Each interrupt has an enable bit, a raw level latch and an active (status) bit. The active bit is what drives the CPU pin.

Software reaches the router through a single-beat 32-bit word bus. Every access carries the index of the requesting CPU. That CPU's index selects which status word a read returns and which status bits a write-1-to-clear may touch. A config register picks the core-map encoding and holds an enable flag. The config register is masked by a read-only feature word. Once the enable flag is set, the config register is locked. Bounce and node-type words are storage only and have no effect on routing.

Top module: `xio_router`

## Requirements
- R1: After reset every CPU pin output is low, and the config, enable, map and status words all read zero.
- R2: A rising input always latches its raw level. It also sets its active bit only if its enable bit is 1. The enable bit for interrupt i is bit i%32 of enable word i/32.
- R3: A falling input clears its raw and active bits. Pin output `irq_o[4*c+p]` stays high while any active interrupt is routed to CPU c and pin p.
- R4: Pin map byte g (word 0x060+g/4, byte g%4) sets the pin for interrupts 32g..32g+31. The pin is the index of the lowest set bit. A zero byte, or a lowest set bit of 4 or above, selects pin 0. A pin map change takes effect immediately.
- R5: Core map byte i (word 0x100+i/4, byte i%4) sets the CPU for interrupt i. With config bit 1 clear, the CPU is the index of the lowest set bit. A zero byte, or a lowest set bit of 4 or above, selects CPU 0.
- R6: With config bit 1 set, the core map byte is the binary CPU id. A byte that names no existing CPU leaves the route unchanged but is still stored for readback.
- R7: When a core map write moves an interrupt whose raw bit is set, the interrupt leaves the old CPU and is re-asserted at the new CPU if it is enabled.
- R8: An enable bit going 0 to 1 on a raw-set interrupt sets its active bit. An enable bit going 1 to 0 clears it.
- R9: Status words (0x040+w) read the active bits routed to the requesting CPU. A write clears each bit written as 1 that is routed to the requester, and leaves the raw bit alone.
- R10: The feature word (0x200) is read-only, and a write to it returns an error. A write to config (0x201) while config bit 0 is set and the data is nonzero returns an error and changes nothing. Any other config write stores the data ANDed with the features.
- R11: Bounce (0x020+w) and node-type (0x070..0x073) words read back what was written and do not change the outputs. Unmapped words read zero and ignore writes.
- R12: Every request is acknowledged exactly one cycle later, with read data and error flag valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Device interrupt levels |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 10 | Word address |
| wdata_i | input | 32 | Write data |
| cpu_i | input | CPU_W | Index of the requesting CPU |
| ack_o | output | 1 | Response valid, one cycle after request |
| err_o | output | 1 | Access error, valid with ack_o |
| rdata_o | output | 32 | Read data, valid with ack_o |
| irq_o | output | 4*N_CPU | Pin level, bit 4*cpu+pin |

## Verification
The hardest state to reach is an interrupt whose raw level is high but whose active bit has been dropped. The bench gets there by having the owning CPU clear the interrupt through the write-1-to-clear path. It then moves the interrupt with a core map write, and the output must reappear on the new CPU with no new input edge. The stimulus first routes the interrupt to CPU 1. It shows that a clear from CPU 0 has no effect, clears the bit from CPU 1, and then remaps the interrupt to CPU 3. Config locking is reached by setting the enable flag through an allowed write and then trying a nonzero write.

// File: rtl/xio_pkg.sv
package xio_pkg;
  localparam int A_EN   = 'h000;
  localparam int A_BNC  = 'h020;
  localparam int A_STS  = 'h040;
  localparam int A_PMAP = 'h060;
  localparam int A_NODE = 'h070;
  localparam int A_CMAP = 'h100;
  localparam int A_FEAT = 'h200;
  localparam int A_CFG  = 'h201;
  localparam int N_NODE = 4;
  localparam int CFG_ON  = 0;
  localparam int CFG_ENC = 1;

  // lowest set bit among the low four; otherwise 0
  function automatic logic [1:0] low_idx4(input logic [7:0] b);
    if (b[0])      return 2'd0;
    else if (b[1]) return 2'd1;
    else if (b[2]) return 2'd2;
    else if (b[3]) return 2'd3;
    else           return 2'd0;
  endfunction
endpackage

// File: rtl/xio_edge.sv
module xio_edge #(
  parameter int N = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/xio_pin_merge.sv
module xio_pin_merge #(
  parameter int N_IRQ = 256,
  parameter int N_CPU = 4,
  parameter int CPU_W = 2,
  localparam int N_GRP = N_IRQ / 32
) (
  input  logic [N_IRQ-1:0] act_i,
  input  logic [CPU_W-1:0] route_i [N_IRQ],
  input  logic [1:0]       gpin_i  [N_GRP],
  output logic [4*N_CPU-1:0] irq_o
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar p = 0; p < 4; p++) begin : g_pin
      always_comb begin
        irq_o[4*c+p] = 1'b0;
        for (int i = 0; i < N_IRQ; i++)
          if (act_i[i] && route_i[i] == CPU_W'(c) && gpin_i[i/32] == 2'(p))
            irq_o[4*c+p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xio_router.sv
module xio_router
  import xio_pkg::*;
#(
  parameter int          N_IRQ    = 256,
  parameter int          N_CPU    = 4,
  parameter logic [31:0] FEATURES = 32'h3,
  localparam int CPU_W = $clog2(N_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [9:0]         addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [CPU_W-1:0]   cpu_i,
  output logic               ack_o,
  output logic               err_o,
  output logic [31:0]        rdata_o,
  output logic [4*N_CPU-1:0] irq_o
);
  localparam int N_GRP = N_IRQ / 32;

  logic [N_IRQ-1:0] en_q, raw_q, act_q, en_d, raw_d, act_d;
  logic [N_IRQ-1:0] rise_w, fall_w;
  logic [CPU_W-1:0] route_q [N_IRQ];
  logic [CPU_W-1:0] route_d [N_IRQ];
  logic [7:0]       cmap_q  [N_IRQ];
  logic [7:0]       pmap_q  [N_GRP];
  logic [1:0]       gpin_w  [N_GRP];
  logic [31:0]      bnc_q   [N_GRP];
  logic [31:0]      node_q  [N_NODE];
  logic [31:0]      cfg_q, rd_w;
  logic [CPU_W:0]   cd;
  logic             wr, cfg_bad;
  logic             ack_q, err_q;
  logic [31:0]      rdata_q;
  int               a;

  assign a       = int'(addr_i);
  assign wr      = req_i && we_i;
  assign cfg_bad = cfg_q[CFG_ON] && (wdata_i != '0);

  // returns {valid, cpu}
  function automatic logic [CPU_W:0] dec_core(input logic [7:0] b, input logic enc);
    logic [7:0] v;
    v = enc ? b : {6'd0, low_idx4(b)};
    return {(int'(v) < N_CPU), v[CPU_W-1:0]};
  endfunction

  xio_edge #(.N(N_IRQ)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(irq_i), .rise_o(rise_w), .fall_o(fall_w)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_gpin
    assign gpin_w[g] = low_idx4(pmap_q[g]);
  end

  xio_pin_merge #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .CPU_W(CPU_W)) u_merge (
    .act_i(act_q), .route_i(route_q), .gpin_i(gpin_w), .irq_o(irq_o)
  );

  // next interrupt state: bus effects first, input edges last
  always_comb begin
    en_d  = en_q;
    raw_d = raw_q;
    act_d = act_q;
    cd    = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      route_d[i] = route_q[i];
      if (wr && i / 32 == a - A_EN) begin
        if (wdata_i[i%32] && !en_q[i] && raw_q[i]) act_d[i] = 1'b1;
        if (!wdata_i[i%32] && en_q[i] && raw_q[i]) act_d[i] = 1'b0;
        en_d[i] = wdata_i[i%32];
      end
      if (wr && i / 32 == a - A_STS && wdata_i[i%32] && route_q[i] == cpu_i)
        act_d[i] = 1'b0;
      if (wr && i / 4 == a - A_CMAP) begin
        cd = dec_core(wdata_i[8*(i%4) +: 8], cfg_q[CFG_ENC]);
        if (cd[CPU_W] && cd[CPU_W-1:0] != route_q[i]) begin
          route_d[i] = cd[CPU_W-1:0];
          if (raw_q[i]) act_d[i] = en_q[i];
        end
      end
      if (rise_w[i]) begin
        raw_d[i] = 1'b1;
        act_d[i] = en_d[i];
      end
      if (fall_w[i]) begin
        raw_d[i] = 1'b0;
        act_d[i] = 1'b0;
      end
    end
  end

  always_comb begin
    rd_w = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (i / 32 == a - A_EN)  rd_w[i%32] = en_q[i];
      if (i / 32 == a - A_STS) rd_w[i%32] = act_q[i] && route_q[i] == cpu_i;
      if (i / 4 == a - A_CMAP) rd_w[8*(i%4) +: 8] = cmap_q[i];
    end
    for (int g = 0; g < N_GRP; g++) begin
      if (g == a - A_BNC)       rd_w = bnc_q[g];
      if (g / 4 == a - A_PMAP)  rd_w[8*(g%4) +: 8] = pmap_q[g];
    end
    for (int n = 0; n < N_NODE; n++)
      if (n == a - A_NODE) rd_w = node_q[n];
    if (a == A_FEAT) rd_w = FEATURES;
    if (a == A_CFG)  rd_w = cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0; raw_q <= '0; act_q <= '0; cfg_q <= '0;
      ack_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
      for (int i = 0; i < N_IRQ; i++) begin
        route_q[i] <= '0;
        cmap_q[i]  <= '0;
      end
      for (int g = 0; g < N_GRP; g++) begin
        pmap_q[g] <= '0;
        bnc_q[g]  <= '0;
      end
      for (int n = 0; n < N_NODE; n++) node_q[n] <= '0;
    end else begin
      en_q  <= en_d;
      raw_q <= raw_d;
      act_q <= act_d;
      for (int i = 0; i < N_IRQ; i++) begin
        route_q[i] <= route_d[i];
        if (wr && i / 4 == a - A_CMAP) cmap_q[i] <= wdata_i[8*(i%4) +: 8];
      end
      for (int g = 0; g < N_GRP; g++) begin
        if (wr && g / 4 == a - A_PMAP) pmap_q[g] <= wdata_i[8*(g%4) +: 8];
        if (wr && g == a - A_BNC)      bnc_q[g]  <= wdata_i;
      end
      for (int n = 0; n < N_NODE; n++)
        if (wr && n == a - A_NODE) node_q[n] <= wdata_i;
      if (wr && a == A_CFG && !cfg_bad) cfg_q <= wdata_i & FEATURES;
      ack_q   <= req_i;
      err_q   <= wr && (a == A_FEAT || (a == A_CFG && cfg_bad));
      rdata_q <= (req_i && !we_i) ? rd_w : '0;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  a_r12_ack_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  a_r12_no_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  a_r10_feat_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && a == A_FEAT) |=> err_o);
  a_r10_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && a == A_CFG && cfg_q[CFG_ON] && wdata_i != '0) |=> (err_o && cfg_q == $past(cfg_q)));
  a_r3_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_w) |=> ((raw_q & $past(fall_w)) == '0));
  a_r2_act_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q & ~raw_q) == '0);
  a_r3_pin_needs_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|act_q));
endmodule

// File: tb/tb_xio_router.sv
module tb_xio_router;
  localparam int N_IRQ = 256;
  localparam int N_CPU = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_IRQ-1:0] irq = '0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] cpu = '0;
  logic ack, err;
  logic [31:0] rdata;
  logic [4*N_CPU-1:0] pins;

  int total = 0, bad = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    logic        cd;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  xio_router #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .FEATURES(32'h3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .cpu_i(cpu), .ack_o(ack), .err_o(err),
    .rdata_o(rdata), .irq_o(pins)
  );

  // monitor: pops one expected response per acknowledge (R12)
  always @(negedge clk) begin
    if (ack) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected ack: actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        if (err !== it.e || (it.cd && rdata !== it.d)) begin
          bad++;
          $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                   it.tag, rdata, err, it.d, it.e);
        end
      end
    end
  end

  task automatic bus(input bit w, input int adr, input logic [31:0] wd, input int c,
                     input logic [31:0] ed, input bit ee, input bit chk_d, input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = adr[9:0]; wdata = wd; cpu = c[1:0];
    sb.push_back('{ed, ee, chk_d, tag});
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input int adr, input logic [31:0] wd, input int c, input string tag);
    bus(1'b1, adr, wd, c, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_err(input int adr, input logic [31:0] wd, input string tag);
    bus(1'b1, adr, wd, 0, '0, 1'b1, 1'b0, tag);
  endtask

  task automatic rd(input int adr, input int c, input logic [31:0] ed, input string tag);
    bus(1'b0, adr, '0, c, ed, 1'b0, 1'b1, tag);
  endtask

  task automatic set_irq(input int k, input logic v);
    @(negedge clk);
    irq[k] = v;
    @(negedge clk);
  endtask

  task automatic chk(input logic [15:0] exp, input string tag);
    total++;
    if (pins !== exp) begin
      bad++;
      $display("FAIL %s: actual pins=%h expected=%h", tag, pins, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(16'h0, "R1 pins");
    rd('h201, 0, 32'h0, "R1 cfg");
    rd('h000, 0, 32'h0, "R1 enable");
    rd('h100, 0, 32'h0, "R1 core map");
    rd('h200, 0, 32'h3, "R10 feature read");

    set_irq(5, 1'b1);
    chk(16'h0, "R2 disabled rise");
    rd('h040, 0, 32'h0, "R2 no status when disabled");
    wr('h000, 32'h20, 0, "R8 enable");
    chk(16'h1, "R8 enable raises pending");
    rd('h040, 0, 32'h20, "R9 status read");
    set_irq(5, 1'b0);
    chk(16'h0, "R3 fall");
    rd('h040, 0, 32'h0, "R3 status cleared");

    wr('h000, 32'hFFFF_FFFF, 0, "R2 enable all");
    set_irq(3, 1'b1);
    set_irq(7, 1'b1);
    chk(16'h1, "R2 two pending");
    set_irq(3, 1'b0);
    chk(16'h1, "R3 other still pending");
    set_irq(7, 1'b0);
    chk(16'h0, "R3 last cleared");

    wr('h060, 32'h4, 0, "R4 pin2");
    set_irq(1, 1'b1);
    chk(16'h4, "R4 pin2");
    wr('h060, 32'h30, 0, "R4 high bit");
    chk(16'h1, "R4 bit4 gives pin0");
    wr('h001, 32'hFFFF_FFFF, 0, "R4 enable word1");
    wr('h060, 32'h0800, 0, "R4 group1 pin3");
    set_irq(40, 1'b1);
    chk(16'h9, "R4 group1 pin3");
    wr('h060, 32'h0, 0, "R4 zero");
    chk(16'h1, "R4 zero byte gives pin0");
    set_irq(1, 1'b0);
    set_irq(40, 1'b0);
    chk(16'h0, "R3 idle");

    wr('h100, 32'h0004_0000, 0, "R5 irq2 cpu2");
    set_irq(2, 1'b1);
    chk(16'h0100, "R5 one-hot cpu2");
    wr('h100, 32'h0010_0000, 0, "R5 bit4");
    chk(16'h0001, "R5 bit4 gives cpu0");
    set_irq(2, 1'b0);

    wr('h102, 32'h0000_0200, 0, "R7 irq9 cpu1");
    set_irq(9, 1'b1);
    chk(16'h0010, "R7 on cpu1");
    wr('h040, 32'h200, 0, "R9 foreign clear");
    chk(16'h0010, "R9 foreign clear ignored");
    rd('h040, 1, 32'h200, "R9 owner status");
    rd('h040, 0, 32'h0, "R9 other status");
    wr('h040, 32'h200, 1, "R9 owner clear");
    chk(16'h0, "R9 owner clear");
    wr('h102, 32'h0000_0800, 0, "R7 move to cpu3");
    chk(16'h1000, "R7 live move reasserts");
    rd('h040, 3, 32'h200, "R7 new owner status");
    set_irq(9, 1'b0);
    chk(16'h0, "R3 idle");

    set_irq(4, 1'b1);
    chk(16'h1, "R8 pending");
    wr('h000, 32'hFFFF_FFEF, 0, "R8 mask");
    chk(16'h0, "R8 mask drops");
    rd('h040, 0, 32'h0, "R8 status dropped");
    wr('h000, 32'hFFFF_FFFF, 0, "R8 unmask");
    chk(16'h1, "R8 unmask restores");
    set_irq(4, 1'b0);

    wr('h201, 32'h2, 0, "R10 cfg");
    rd('h201, 0, 32'h2, "R10 cfg readback");
    wr('h201, 32'h1, 0, "R10 cfg on");
    rd('h201, 0, 32'h1, "R10 cfg on readback");
    wr_err('h201, 32'h3, "R10 locked write");
    rd('h201, 0, 32'h1, "R10 locked value kept");
    wr('h201, 32'h0, 0, "R10 zero allowed");
    rd('h201, 0, 32'h0, "R10 zero readback");
    wr('h201, 32'h6, 0, "R10 masked");
    rd('h201, 0, 32'h2, "R10 masked by features");

    wr('h103, 32'h3, 0, "R6 irq12 cpu3");
    set_irq(12, 1'b1);
    chk(16'h1000, "R6 encoded cpu3");
    wr('h103, 32'h7, 0, "R6 bad cpu");
    chk(16'h1000, "R6 bad id ignored");
    rd('h103, 0, 32'h7, "R6 byte stored");
    wr('h103, 32'h1, 0, "R6 cpu1");
    chk(16'h0010, "R6 encoded cpu1");
    set_irq(12, 1'b0);

    wr_err('h200, 32'h0, "R10 feature write");
    rd('h200, 0, 32'h3, "R10 feature unchanged");

    wr('h020, 32'h5A5A, 0, "R11 bounce");
    rd('h020, 0, 32'h5A5A, "R11 bounce readback");
    wr('h072, 32'hC3, 0, "R11 node");
    rd('h072, 0, 32'hC3, "R11 node readback");
    chk(16'h0, "R11 no routing effect");
    wr('h010, 32'hFFFF_FFFF, 0, "R11 unmapped write");
    rd('h010, 0, 32'h0, "R11 unmapped read");
    rd('h300, 0, 32'h0, "R12 unmapped high read");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R12 missing ack: actual=%0d expected=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule